// File: doc/BRIEF.md
# Sixteen-Channel 12-bit Grayscale PWM Driver

This block turns a set of 12-bit brightness codes into on/off enable pulses, one per channel. All channels share one grayscale counter that advances on the rising edge of the grayscale clock. A blanking input frames each PWM period. While it is high, the counter is held at zero and every enable is low. Once it is low, counting starts.

At the first grayscale clock edge after blanking drops, the counter reaches 1. On that edge, every channel with a nonzero code switches on. A channel stays on for exactly as many clock periods as its code, and then switches off. The counter stops at its all-ones value, and there every enable is forced low. Raising the blank input again, at any point, kills the enables straight away and zeroes the count, which readies the next period.

The codes arrive on one flat bus. Each channel copies its code on the first edge of a period. The copy is used for the whole period, so the driving logic can load new codes while a period is running.

Top module: `gs_pwm_driver`

## Requirements
- R1: While `rst_n` is low, the counter is zero and every bit of `out_en` is low.
- R2: While `blank` is high, every bit of `out_en` is low with no clock edge needed, and the counter is held at zero on each edge.
- R3: On the first rising edge of `gs_clk` with `blank` low, the counter goes to 1. On that edge, every channel whose code is nonzero turns on.
- R4: Each later rising edge with `blank` low adds one to the counter until it is all ones.
- R5: A channel with code v, 1 <= v <= 4094, is on after edges 1 through v of the period and off after edge v+1 and later. Its pulse is exactly v clock periods wide.
- R6: A channel whose code is zero never turns on during the period.
- R7: The counter stops at 4095 (all ones) and holds there. While it is there, every `out_en` bit is low, which includes channels with code 4095.
- R8: Raising `blank` in the middle of a period zeroes the counter. The next period then begins again at count 1.
- R9: Each channel samples its code on the first edge of a period. Code changes later in the period are ignored until the next period starts.
- R10: Channel n takes its code from `gs_level[12n+11:12n]` and drives `out_en[n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gs_clk | input | 1 | Grayscale clock; the counter advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blank | input | 1 | High: outputs off and counter cleared; falling starts a period |
| gs_level | input | 192 | Sixteen 12-bit codes, channel n in bits [12n+11:12n] |
| out_en | output | 16 | Per-channel on/off enable |

## Verification
The assertions check, on every edge, these properties:
- A high blank means all enables are low and a cleared count on the next edge.
- The counter steps by exactly one while it is below all ones.
- At all ones the counter stays put.
- At all ones no enable is high.

Some behaviours concern one channel's pulse over a whole period, so only the bench scenarios can show them: the exact width of each channel's pulse, a silent zero-code channel, codes loaded mid-period being ignored until the next period, and the bit position of each channel's field. The bench runs one full period into saturation, and then a second period that is cut short by blanking and restarted.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
   // Default geometry of the driver
   localparam int unsigned DEF_CHANNELS = 16;
   localparam int unsigned DEF_GS_BITS  = 12;
   // Limits accepted by the elaboration checks
   localparam int unsigned MIN_GS_BITS  = 2;
   localparam int unsigned MAX_GS_BITS  = 16;
endpackage

// File: rtl/gs_pwm_counter.sv
// Shared grayscale counter: cleared by blank, saturates at all ones.
module gs_pwm_counter #(
   parameter int unsigned GS_BITS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blank,
   output logic [GS_BITS-1:0] count,
   output logic               start,
   output logic               full
);
   localparam logic [GS_BITS-1:0] STEP = GS_BITS'(1);

   assign full  = &count;
   assign start = (count == '0) && !blank;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (blank)
         count <= '0;
      else if (!full)
         count <= count + STEP;
   end
endmodule

// File: rtl/gs_pwm_channel.sv
// One PWM channel: captures its code at period start, ends its pulse on match.
module gs_pwm_channel #(
   parameter int unsigned GS_BITS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blank,
   input  logic               start,
   input  logic [GS_BITS-1:0] count,
   input  logic [GS_BITS-1:0] level_in,
   output logic               on
);
   logic [GS_BITS-1:0] level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         on      <= 1'b0;
      end else if (blank) begin
         on      <= 1'b0;
      end else if (start) begin
         level_q <= level_in;
         on      <= |level_in;
      end else if (count == level_q) begin
         on      <= 1'b0;
      end
   end
endmodule

// File: rtl/gs_pwm_driver.sv
// Multi-channel grayscale PWM driver with blank-framed periods.
module gs_pwm_driver
   import gs_pwm_pkg::*;
#(
   parameter int unsigned CHANNELS = DEF_CHANNELS,
   parameter int unsigned GS_BITS  = DEF_GS_BITS
) (
   input  logic                        gs_clk,
   input  logic                        rst_n,
   input  logic                        blank,
   input  logic [CHANNELS*GS_BITS-1:0] gs_level,
   output logic [CHANNELS-1:0]         out_en
);
   // Elaboration-time parameter checks
   if (GS_BITS < MIN_GS_BITS || GS_BITS > MAX_GS_BITS) begin : g_bad_width
      $error("gs_pwm_driver: GS_BITS out of range");
   end
   if (CHANNELS < 1) begin : g_bad_channels
      $error("gs_pwm_driver: CHANNELS must be at least 1");
   end

   logic [GS_BITS-1:0]  gs_count;
   logic                cyc_start;
   logic                cnt_full;
   logic [CHANNELS-1:0] chan_on;

   gs_pwm_counter #(.GS_BITS(GS_BITS)) u_counter (
      .clk   (gs_clk),
      .rst_n (rst_n),
      .blank (blank),
      .count (gs_count),
      .start (cyc_start),
      .full  (cnt_full)
   );

   for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
      gs_pwm_channel #(.GS_BITS(GS_BITS)) u_chan (
         .clk      (gs_clk),
         .rst_n    (rst_n),
         .blank    (blank),
         .start    (cyc_start),
         .count    (gs_count),
         .level_in (gs_level[i*GS_BITS +: GS_BITS]),
         .on       (chan_on[i])
      );
      // blank and saturation gate the enable without waiting for an edge
      assign out_en[i] = chan_on[i] & ~blank & ~cnt_full;
   end
endmodule

// File: rtl/gs_pwm_driver_chk.sv
// Property checker for gs_pwm_driver, attached with bind.
module gs_pwm_driver_chk #(
   parameter int unsigned CHANNELS = 16,
   parameter int unsigned GS_BITS  = 12
) (
   input logic                gs_clk,
   input logic                rst_n,
   input logic                blank,
   input logic [GS_BITS-1:0]  count,
   input logic [CHANNELS-1:0] out_en
);
   localparam logic [GS_BITS-1:0] TOP = '1;

   a_r2_blank_off: assert property (@(posedge gs_clk) disable iff (!rst_n)
      blank |-> (out_en == '0));

   a_r8_blank_clears: assert property (@(posedge gs_clk) disable iff (!rst_n)
      blank |=> (count == '0));

   a_r4_step_one: assert property (@(posedge gs_clk) disable iff (!rst_n)
      (!blank && count != TOP) |=> (count == $past(count) + GS_BITS'(1)));

   a_r7_sat_hold: assert property (@(posedge gs_clk) disable iff (!rst_n)
      (!blank && count == TOP) |=> (count == TOP));

   a_r7_sat_off: assert property (@(posedge gs_clk) disable iff (!rst_n)
      (count == TOP) |-> (out_en == '0));
endmodule

bind gs_pwm_driver gs_pwm_driver_chk #(.CHANNELS(CHANNELS), .GS_BITS(GS_BITS)) u_chk (
   .gs_clk (gs_clk),
   .rst_n  (rst_n),
   .blank  (blank),
   .count  (gs_count),
   .out_en (out_en)
);

// File: tb/tb_gs_pwm_driver.sv
module tb_gs_pwm_driver;
   localparam int CLK_PERIOD = 10;
   localparam int CH   = 16;
   localparam int W    = 12;
   localparam int MAXC = 4095;

   typedef struct {
      logic [CH-1:0] exp;
      string         tag;
   } item_t;

   logic            gs_clk = 1'b0;
   logic            rst_n  = 1'b0;
   logic            blank  = 1'b1;
   logic [CH*W-1:0] gs_level;
   logic [CH-1:0]   out_en;

   logic [W-1:0] lvl [CH];
   logic [W-1:0] cap [CH];
   item_t        sb_q [$];
   int           k      = 0;
   int           errors = 0;
   int           checks = 0;

   always #(CLK_PERIOD/2) gs_clk = ~gs_clk;

   always_comb
      for (int c = 0; c < CH; c++) gs_level[c*W +: W] = lvl[c];

   gs_pwm_driver dut (
      .gs_clk   (gs_clk),
      .rst_n    (rst_n),
      .blank    (blank),
      .gs_level (gs_level),
      .out_en   (out_en)
   );

   task automatic check(logic [CH-1:0] act, logic [CH-1:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: out_en=%h expected %h", tag, act, exp);
      end
   endtask

   // Model: on after edges 1..code, never at saturation
   function automatic logic [CH-1:0] expect_at(int kk);
      logic [CH-1:0] e;
      for (int c = 0; c < CH; c++)
         e[c] = (kk >= 1) && (kk <= int'(cap[c])) && (kk < MAXC);
      return e;
   endfunction

   function automatic string tag_for(int kk);
      if (kk == 1)    return "R3 R6 R10 first edge";
      if (kk >= MAXC) return "R7 saturated";
      return "R4 R5 R6 R10 count";
   endfunction

   // Monitor: pops one expected item per edge, samples a quarter period later
   initial forever begin
      item_t it;
      @(posedge gs_clk);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         check(out_en, it.exp, it.tag);
      end
   end

   task automatic hold_blank(int n, string note);
      blank = 1'b1;
      k = 0;
      repeat (n) begin
         sb_q.push_back('{exp: '0, tag: note});
         @(posedge gs_clk);
         @(negedge gs_clk);
      end
   endtask

   task automatic begin_cycle();
      blank = 1'b0;
      k = 0;
      for (int c = 0; c < CH; c++) cap[c] = lvl[c];
   endtask

   task automatic run_edges(int n, string note);
      repeat (n) begin
         k++;
         sb_q.push_back('{exp: expect_at(k), tag: {note, " ", tag_for(k)}});
         @(posedge gs_clk);
         @(negedge gs_clk);
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int c = 0; c < CH; c++) lvl[c] = '0;
      repeat (3) @(negedge gs_clk);
      check(out_en, '0, "R1 reset");
      rst_n = 1'b1;
      hold_blank(3, "R2 blank held");

      // Period A: edge codes, zero codes, full run into saturation
      lvl[0]  = 12'd0;    lvl[1]  = 12'd1;    lvl[2]  = 12'd2;    lvl[3]  = 12'd5;
      lvl[4]  = 12'd4094; lvl[5]  = 12'd4095; lvl[6]  = 12'hABC;  lvl[7]  = 12'h123;
      lvl[8]  = 12'd0;    lvl[9]  = 12'd7;    lvl[10] = 12'd100;  lvl[11] = 12'h800;
      lvl[12] = 12'h7FF;  lvl[13] = 12'd3;    lvl[14] = 12'h555;  lvl[15] = 12'h0F0;
      begin_cycle();
      run_edges(4100, "A");
      hold_blank(2, "R2 R8 end of period");

      // Period B: codes change mid-period, then blank cuts it short
      for (int c = 0; c < CH; c++) lvl[c] = W'(c*3 + 4);
      lvl[0] = '0;
      begin_cycle();
      run_edges(3, "B");
      for (int c = 0; c < CH; c++) lvl[c] = 12'd60;
      run_edges(14, "R9 mid-change");
      blank = 1'b1;
      #1;
      check(out_en, '0, "R2 immediate off");
      @(negedge gs_clk);
      hold_blank(2, "R2 R8 cut short");
      begin_cycle();
      run_edges(65, "R8 R9 restart");

      #(CLK_PERIOD);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule